// File: doc/BRIEF.md
# Scanner Front-End Offset and Gain Calibration Sequencer

This block runs on the host side of a scanner analog front end and carries out its black-level and white-level calibration without software in the loop. After a start pulse it programs the front end's configuration register with the requested operating mode. It then loads every channel's offset register with the code for zero offset and every gain register with the code for unity gain. After that it runs a loop. It requests a dark-line scan and sums the ADC samples for each channel. From that sum it derives corrected offset codes and writes them. It then requests a white-line scan and derives gain codes from the white level. The loop repeats until each measured channel's white level lies within a tolerance of ADC full scale.

Register writes leave through a one-cycle write strobe with a 3-bit address and an 8-bit data byte. Scans are requested with a level that is held until the scanning side answers with a one-cycle done pulse. While a scan runs, samples arrive one per cycle, each tagged with its channel number. The block ends either with a held done flag or, once its iteration budget is spent, with a held fail flag. In one-channel mode only the channel chosen by the mode word is programmed and measured.

Top module: `cal_seq`

## Requirements
- R1: One cycle after start is sampled in an idle, done or fail state, the block writes address 0 with data {0, cfg_word} (cfg_word captured at start).
- R2: Next, one cycle per channel slot, it writes the offset register of each active channel (address 1 + channel) with C0h, then the gain register of each active channel (address 4 + channel) with 00h, in ascending channel order. The first slot follows the configuration write by one cycle. An inactive channel's slot passes with no write.
- R3: scan_req stays high from the request until the cycle in which scan_done is seen. Every iteration makes a dark scan (scan_white = 0) before a white scan (scan_white = 1).
- R4: A channel's scan value is the sum of the samples tagged with that channel during the scan, shifted right by PIX_LOG2 (2, so 4 samples). Samples tagged 3 are dropped.
- R5: After a dark scan the new offset code is the current code minus floor(dark × 5 / 8), saturating at 00h. It is written to address 1 + c in cycle 1 + c after the cycle carrying scan_done.
- R6: After a white scan the new gain code is the largest k in 0..31 with white × T(k) ≤ 4095 × T(current code), where T(k) = 256 + floor(881 × k / 31). It is written as {000, k} to address 4 + c in cycle 1 + c after scan_done.
- R7: If every active channel's white value is at least 4095 − floor(4095 × TOL_PCT / 100) (4014 by default), done rises after the gain writes. Otherwise a new dark scan starts.
- R8: If MAX_ITER (4) iterations end without convergence, fail rises. done and fail are never high together, and both hold until the next start.
- R9: With cfg_word bit 2 set, only the channel numbered by cfg_word bits [5:4] (0, 1 or 2) is active. With bit 2 clear, all three are active.
- R10: After reset, scan_req, wr_en, done and fail are low and the block waits for start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a calibration run |
| cfg_word | input | 7 | Operating mode word written to the configuration register |
| scan_req | output | 1 | Scan request, held until scan_done |
| scan_white | output | 1 | 0 = dark line, 1 = white line |
| scan_done | input | 1 | One-cycle pulse ending the requested scan |
| smp_valid | input | 1 | ADC sample valid |
| smp_chan | input | 2 | Channel tag of the sample |
| smp_data | input | 12 | ADC sample |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 3 | Register address |
| wr_data | output | 8 | Register data |
| done | output | 1 | Calibration converged |
| fail | output | 1 | Iteration budget spent without convergence |

## Verification
Each register write has a fixed distance from the event that triggers it. The configuration write comes one cycle after start. Initial write slot n comes 2 + n cycles after start. A computed offset or gain write for channel c comes 1 + c cycles after the cycle carrying scan_done. The bench logs every write together with its distance from the last start or scan_done it drove, and compares address, data and distance against a list built by its own model. It drives start, samples and scan_done on falling edges and samples outputs on falling edges, so each value is read half a cycle after the rising edge that produced it.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CFG, S_IOFF, S_IGAIN, S_DARK, S_WOFF,
    S_WHITE, S_WGAIN, S_CHECK, S_DONE, S_FAIL
  } cal_state_e;

  localparam logic [7:0] OFF_ZERO = 8'hC0;

  // offset steps are ~0.78 mV, ADC LSB ~0.49 mV: one ADC count is 5/8 step
  function automatic logic [7:0] off_next(input logic [7:0] cur, input int unsigned dark);
    int unsigned steps;
    steps = (dark * 5) >> 3;
    if (steps >= 32'(cur)) return 8'h00;
    return cur - steps[7:0];
  endfunction

  // linear gain of code k scaled by 256
  function automatic int unsigned gain_thr(input int unsigned k);
    return 256 + (k * 881) / 31;
  endfunction

  function automatic logic [4:0] gain_pick(input logic [4:0] cur, input int unsigned white,
                                           input int unsigned fs);
    int unsigned lim;
    logic [4:0]  code;
    lim  = fs * gain_thr(32'(cur));
    code = '0;
    for (int unsigned k = 1; k < 32; k++)
      if (white * gain_thr(k) <= lim) code = 5'(k);
    return code;
  endfunction

endpackage

// File: rtl/cal_seq_accum.sv
module cal_seq_accum #(
  parameter int NCH      = 3,
  parameter int ADC_W    = 12,
  parameter int PIX_LOG2 = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      clr,
  input  logic                      smp_valid,
  input  logic [1:0]                smp_chan,
  input  logic [ADC_W-1:0]          smp_data,
  output logic [NCH-1:0][ADC_W-1:0] avg
);
  localparam int SUM_W = ADC_W + PIX_LOG2;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SUM_W-1:0] sum_q;
    logic             hit;
    assign hit = en && smp_valid && (smp_chan == 2'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sum_q <= '0;
      else if (clr) sum_q <= hit ? SUM_W'(smp_data) : '0;
      else if (hit) sum_q <= sum_q + SUM_W'(smp_data);
    end

    assign avg[c] = sum_q[SUM_W-1:PIX_LOG2];
  end
endmodule

// File: rtl/cal_seq_math.sv
module cal_seq_math
  import cal_seq_pkg::*;
#(
  parameter int NCH       = 3,
  parameter int ADC_W     = 12,
  parameter int FS        = 4095,
  parameter int CLOSE_MIN = 4014
) (
  input  logic [NCH-1:0][ADC_W-1:0] avg,
  input  logic [NCH-1:0][7:0]       cur_off,
  input  logic [NCH-1:0][4:0]       cur_gain,
  output logic [NCH-1:0][7:0]       new_off,
  output logic [NCH-1:0][4:0]       new_gain,
  output logic [NCH-1:0]            close
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign new_off[c]  = off_next(cur_off[c], 32'(avg[c]));
    assign new_gain[c] = gain_pick(cur_gain[c], 32'(avg[c]), 32'(FS));
    assign close[c]    = 32'(avg[c]) >= 32'(CLOSE_MIN);

    // R5
    always_comb off_no_rise_chk: assert (new_off[c] <= cur_off[c]);
  end
endmodule

// File: rtl/cal_seq.sv
module cal_seq
  import cal_seq_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int ADC_W    = 12,
  parameter int PIX_LOG2 = 2,
  parameter int TOL_PCT  = 2,
  parameter int MAX_ITER = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [6:0]       cfg_word,
  output logic             scan_req,
  output logic             scan_white,
  input  logic             scan_done,
  input  logic             smp_valid,
  input  logic [1:0]       smp_chan,
  input  logic [ADC_W-1:0] smp_data,
  output logic             wr_en,
  output logic [2:0]       wr_addr,
  output logic [7:0]       wr_data,
  output logic             done,
  output logic             fail
);
  localparam int FS        = (1 << ADC_W) - 1;
  localparam int CLOSE_MIN = FS - (FS * TOL_PCT) / 100;
  localparam int IW        = $clog2(MAX_ITER + 1);

  cal_state_e            st;
  logic [1:0]            wch;
  logic [IW-1:0]         iter;
  logic [6:0]            cfg_q;
  logic                  scan_first;
  logic [NCH-1:0][7:0]   cur_off;
  logic [NCH-1:0][4:0]   cur_gain;
  logic [NCH-1:0][ADC_W-1:0] avg;
  logic [NCH-1:0][7:0]   new_off;
  logic [NCH-1:0][4:0]   new_gain;
  logic [NCH-1:0]        close;
  logic [NCH-1:0]        act;

  // named events for the checks
  logic evt_conv, evt_last_w, evt_last_iter, in_scan;

  always_comb
    for (int c = 0; c < NCH; c++)
      act[c] = !cfg_q[2] || (cfg_q[5:4] == 2'(c));

  assign evt_conv      = &(close | ~act);
  assign evt_last_w    = (wch == 2'(NCH - 1));
  assign evt_last_iter = (iter == IW'(MAX_ITER - 1));
  assign in_scan       = (st == S_DARK) || (st == S_WHITE);

  cal_seq_accum #(.NCH(NCH), .ADC_W(ADC_W), .PIX_LOG2(PIX_LOG2)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(in_scan), .clr(scan_first),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data), .avg(avg)
  );

  cal_seq_math #(.NCH(NCH), .ADC_W(ADC_W), .FS(FS), .CLOSE_MIN(CLOSE_MIN)) u_math (
    .avg(avg), .cur_off(cur_off), .cur_gain(cur_gain),
    .new_off(new_off), .new_gain(new_gain), .close(close)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      wch        <= '0;
      iter       <= '0;
      cfg_q      <= '0;
      scan_first <= 1'b0;
      cur_off    <= {NCH{OFF_ZERO}};
      cur_gain   <= '0;
    end else begin
      scan_first <= 1'b0;
      case (st)
        S_IDLE, S_DONE, S_FAIL:
          if (start) begin
            st       <= S_CFG;
            cfg_q    <= cfg_word;
            iter     <= '0;
            wch      <= '0;
            cur_off  <= {NCH{OFF_ZERO}};
            cur_gain <= '0;
          end
        S_CFG: st <= S_IOFF;
        S_IOFF:
          if (evt_last_w) begin wch <= '0; st <= S_IGAIN; end
          else wch <= wch + 2'd1;
        S_IGAIN:
          if (evt_last_w) begin st <= S_DARK; scan_first <= 1'b1; end
          else wch <= wch + 2'd1;
        S_DARK:
          if (scan_done) begin st <= S_WOFF; wch <= '0; end
        S_WOFF: begin
          if (act[wch]) cur_off[wch] <= new_off[wch];
          if (evt_last_w) begin st <= S_WHITE; scan_first <= 1'b1; end
          else wch <= wch + 2'd1;
        end
        S_WHITE:
          if (scan_done) begin st <= S_WGAIN; wch <= '0; end
        S_WGAIN: begin
          if (act[wch]) cur_gain[wch] <= new_gain[wch];
          if (evt_last_w) st <= S_CHECK;
          else wch <= wch + 2'd1;
        end
        S_CHECK:
          if (evt_conv)           st <= S_DONE;
          else if (evt_last_iter) st <= S_FAIL;
          else begin
            iter       <= iter + IW'(1);
            st         <= S_DARK;
            scan_first <= 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = 3'd0;
    wr_data = 8'h00;
    case (st)
      S_CFG:   begin wr_en = 1'b1;     wr_data = {1'b0, cfg_q}; end
      S_IOFF:  begin wr_en = act[wch]; wr_addr = 3'd1 + 3'(wch); wr_data = OFF_ZERO; end
      S_IGAIN: begin wr_en = act[wch]; wr_addr = 3'd4 + 3'(wch); end
      S_WOFF:  begin wr_en = act[wch]; wr_addr = 3'd1 + 3'(wch); wr_data = new_off[wch]; end
      S_WGAIN: begin wr_en = act[wch]; wr_addr = 3'd4 + 3'(wch); wr_data = {3'b000, new_gain[wch]}; end
      default: ;
    endcase
  end

  assign scan_req   = in_scan;
  assign scan_white = (st == S_WHITE);
  assign done       = (st == S_DONE);
  assign fail       = (st == S_FAIL);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_req && !scan_done |=> scan_req);
  // R8
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  // R8
  fail_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(evt_last_iter) && !$past(evt_conv));
  // R7
  done_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(evt_conv));
  // R6
  gain_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr >= 3'd4 |-> wr_data[7:5] == 3'b000);
  // R10
  no_write_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_req |-> !wr_en);
endmodule

// File: tb/cal_seq_tb.sv
module cal_seq_tb;
  localparam int MAXI = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [6:0] cfg_word = '0;
  logic scan_req, scan_white, scan_done = 1'b0;
  logic smp_valid = 1'b0;
  logic [1:0] smp_chan = '0;
  logic [11:0] smp_data = '0;
  logic wr_en, done, fail;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;

  cal_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word),
    .scan_req(scan_req), .scan_white(scan_white), .scan_done(scan_done),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .fail(fail)
  );

  always #4 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0, ref_cyc = 0, nlog = 0;
  bit finished = 0;
  int lg_addr[256], lg_data[256], lg_rel[256];
  int ex_addr[256], ex_data[256], ex_rel[256];
  string ex_tag[256];
  int nex;
  int dk[MAXI][3], wt[MAXI][3];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (wr_en && nlog < 256) begin
      lg_addr[nlog] = int'(wr_addr);
      lg_data[nlog] = int'(wr_data);
      lg_rel[nlog]  = cyc - ref_cyc;
      nlog++;
    end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit is_act(input logic [6:0] cfg, input int c);
    return !cfg[2] || (int'(cfg[5:4]) == c);
  endfunction

  function automatic int exp_off(input int cur, input int dark);
    int r;
    r = cur - (dark * 5) / 8;
    return (r < 0) ? 0 : r;
  endfunction

  function automatic int thr(input int k);
    return 256 + (881 * k) / 31;
  endfunction

  function automatic int exp_gain(input int cur, input int white);
    for (int k = 31; k > 0; k--)
      if (white * thr(k) <= 4095 * thr(cur)) return k;
    return 0;
  endfunction

  function automatic int dev(input int p);
    case (p)
      0: return 3;
      1: return -3;
      2: return 1;
      default: return -1;
    endcase
  endfunction

  task automatic push(input int a, input int d, input int rel, input string tag);
    ex_addr[nex] = a; ex_data[nex] = d; ex_rel[nex] = rel; ex_tag[nex] = tag;
    nex++;
  endtask

  task automatic run_cal(input logic [6:0] cfg);
    int scans = 0, guard = 0, it;
    int off[3], gn[3];
    bit conv, edone = 0, efail = 0;
    nlog = 0;
    @(negedge clk);
    cfg_word = cfg; start = 1'b1; ref_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    while (!(done || fail) && guard < 4000) begin
      if (scan_req) begin
        chk(scan_white == 1'(scans % 2), "R3", "scan kind", int'(scan_white), scans % 2);
        it = (scans / 2 < MAXI) ? scans / 2 : MAXI - 1;
        for (int c = 0; c < 3; c++)
          for (int p = 0; p < 4; p++) begin
            smp_valid = 1'b1; smp_chan = 2'(c);
            smp_data = 12'((scan_white ? wt[it][c] : dk[it][c]) + dev(p));
            @(negedge clk);
          end
        smp_chan = 2'd3; smp_data = 12'hFFF;   // R4: tag 3 dropped
        @(negedge clk);
        smp_valid = 1'b0;
        chk(scan_req == 1'b1, "R3", "request held", int'(scan_req), 1);
        scan_done = 1'b1; ref_cyc = cyc;
        @(negedge clk);
        scan_done = 1'b0;
        scans++;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    // expected write list
    nex = 0;
    push(0, int'(cfg), 1, "R1");
    for (int c = 0; c < 3; c++) if (is_act(cfg, c)) push(1 + c, 8'hC0, 2 + c, "R2");
    for (int c = 0; c < 3; c++) if (is_act(cfg, c)) push(4 + c, 0, 5 + c, "R2");
    for (int c = 0; c < 3; c++) begin off[c] = 8'hC0; gn[c] = 0; end
    for (int i = 0; i < MAXI; i++) begin
      for (int c = 0; c < 3; c++) if (is_act(cfg, c)) begin
        off[c] = exp_off(off[c], dk[i][c]);
        push(1 + c, off[c], 1 + c, cfg[2] ? "R9" : "R5");
      end
      conv = 1;
      for (int c = 0; c < 3; c++) if (is_act(cfg, c)) begin
        gn[c] = exp_gain(gn[c], wt[i][c]);
        push(4 + c, gn[c], 1 + c, cfg[2] ? "R9" : "R6");
        if (wt[i][c] < 4014) conv = 0;
      end
      if (conv) begin edone = 1; break; end
      if (i == MAXI - 1) efail = 1;
    end
    chk(nlog == nex, "R2", "write count", nlog, nex);
    for (int i = 0; i < nex && i < nlog; i++) begin
      chk(lg_addr[i] == ex_addr[i], ex_tag[i], "write address", lg_addr[i], ex_addr[i]);
      chk(lg_data[i] == ex_data[i], ex_tag[i], "write data", lg_data[i], ex_data[i]);
      chk(lg_rel[i] == ex_rel[i], ex_tag[i], "write cycle", lg_rel[i], ex_rel[i]);
    end
    chk(done == edone, "R7", "done", int'(done), int'(edone));
    chk(fail == efail, "R8", "fail", int'(fail), int'(efail));
    repeat (3) @(negedge clk);
    chk(done == edone && fail == efail, "R8", "status held", int'({done, fail}), int'({edone, efail}));
  endtask

  task automatic fill(input int dlo, input int dhi, input int wlo, input int whi);
    for (int i = 0; i < MAXI; i++)
      for (int c = 0; c < 3; c++) begin
        dk[i][c] = int'($urandom_range(dhi, dlo));
        wt[i][c] = int'($urandom_range(whi, wlo));
      end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!wr_en && !scan_req && !done && !fail, "R10", "reset outputs",
        int'({wr_en, scan_req, done, fail}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_en && !scan_req, "R10", "idle without start", int'({wr_en, scan_req}), 0);

    // two iterations, three channels
    fill(10, 300, 1200, 3500);
    for (int c = 0; c < 3; c++) wt[1][c] = int'($urandom_range(4092, 4014));
    run_cal(7'h00);

    // saturated offsets and top gain code, never converges
    for (int i = 0; i < MAXI; i++)
      for (int c = 0; c < 3; c++) begin dk[i][c] = 3000; wt[i][c] = 100; end
    run_cal(7'h00);

    // one-channel mode on channel 1 (R9), other bits copied (R1)
    fill(10, 300, 500, 2000);
    wt[0][1] = 4050;
    run_cal(7'h5F);

    // tolerance edge: exactly at the limit (R7)
    fill(5, 100, 4014, 4014);
    run_cal(7'h00);
    // one channel just below the limit
    fill(5, 100, 4014, 4014);
    wt[0][1] = 4013;
    for (int c = 0; c < 3; c++) wt[1][c] = 4092;
    run_cal(7'h00);

    // random runs
    for (int t = 0; t < 8; t++) begin
      int sel;
      logic [6:0] cfg;
      sel = int'($urandom_range(3, 0));
      cfg = (sel == 0) ? 7'h00 : (7'h04 | 7'(((sel - 1) & 3) << 4));
      cfg = cfg | (7'($urandom) & 7'h4B);
      fill(3, 400, 2500, 4092);
      run_cal(cfg);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule